// File: doc/BRIEF.md
# Local Countdown Timer

A per-processor 32-bit countdown timer for an interrupt controller. Software programs it with three register writes: an interrupt entry that holds the vector, a mask bit and the mode; a divide setting that picks a power-of-two prescale of the core clock; and an initial count. Writing the initial count copies the value into the current count at once. A nonzero value starts the countdown and zero stops it.

The current count drops by one on every divided tick. When it runs out, the block emits a one-cycle edge interrupt request that carries the entry's vector, unless the entry is masked. In one-shot mode the timer then rests at zero. In periodic mode it reloads from the initial count and keeps running.

A parameter says whether the deadline mode is supported. If it is, selecting that mode makes the block ignore initial-count writes. If it is not, the upper mode bit is dropped from every entry write. Bus decoding, prioritisation and a time-stamp based deadline comparator belong to neighbouring blocks.

Top module: `local_countdown_timer`

## Requirements
- R1: After reset the current count and the initial count are 0 and no interrupt is requested. The entry reads back as 0x0001_0000: masked, one-shot, vector 0.
- R2: A write with `wr_sel`=1 loads the initial count and the current count with `wr_data` in the same cycle. A nonzero value restarts the countdown from that value, even while the timer is already running.
- R3: With initial count N and divide factor D, the interrupt request of a one-shot run appears exactly N·D clock cycles after the loading edge.
- R4: A write with `wr_sel`=2 sets the divide code from `wr_data` bits {3,1,0}, taken in that order. Codes 000 to 110 give divide-by-2 to divide-by-128, and code 111 gives divide-by-1.
- R5: The entry is written with `wr_sel`=0. It holds the vector in bits 7:0, the mask in bit 16 and the mode in bits 18:17 (00 one-shot, 01 periodic, 10 deadline). On expiry, `irq_req` is high for one cycle with `irq_vec` equal to the vector, but only when the mask is clear.
- R6: In periodic mode an expiry reloads the current count from the initial count and the countdown goes on, so expiries recur every N·D cycles.
- R7: In one-shot mode an expiry leaves the current count at 0 and the timer stopped, and it stays at 0 after that.
- R8: Writing an initial count of 0 stops a running countdown. The current count becomes 0 and no interrupt follows.
- R9: With deadline support enabled and the entry in mode 10, initial-count writes are ignored. Neither the initial count nor the current count changes.
- R10: With deadline support disabled, an entry write clears mode bit 18, so writing mode 10 reads back as mode 00.
- R11: While running, the current count decreases by exactly one per divided tick. With divide-by-4, it has dropped by 2 eight cycles after loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 entry, 1 initial count, 2 divide |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Current count |
| init_count | output | 32 | Initial count readback |
| entry_word | output | 32 | Entry readback (vector, mask, mode) |
| irq_req | output | 1 | One-cycle interrupt request on expiry |
| irq_vec | output | 8 | Vector carried with the request |

## Verification
The assertions assume that `wr_en` and `wr_data` are driven to known values from the first clock after reset. They also assume that the divide code and the entry mode are not rewritten in the same cycle that a countdown expires. The stimulus meets both conditions. It changes inputs only at falling edges, holds `wr_en` low during reset, and waits for each run to finish before it reprograms the divide or the entry. The one exception is a deliberate stop or reload of the initial count, which is the behaviour under test. A second instance with deadline support enabled receives the same writes, so the ignored-load behaviour can be observed at its readback ports.

// File: rtl/lct_pkg.sv
package lct_pkg;

   typedef enum logic [1:0] {
      MODE_ONESHOT  = 2'b00,
      MODE_PERIODIC = 2'b01,
      MODE_DEADLINE = 2'b10,
      MODE_RSVD     = 2'b11
   } tmode_e;

   typedef enum logic [1:0] {
      SEL_ENTRY = 2'd0,
      SEL_INIT  = 2'd1,
      SEL_DIV   = 2'd2,
      SEL_NONE  = 2'd3
   } wsel_e;

   localparam int ENTRY_MASK_BIT = 16;
   localparam int ENTRY_MODE_LO  = 17;
   localparam int ENTRY_MODE_HI  = 18;
   localparam int MAX_SHIFT      = 7;
   localparam int DIV_CODE_W     = 3;

   // divide code {b3,b1,b0}: 111 -> shift 0, otherwise code+1
   function automatic logic [DIV_CODE_W-1:0] code_to_shift(input logic [DIV_CODE_W-1:0] code);
      logic [DIV_CODE_W-1:0] s;
      if (code == {DIV_CODE_W{1'b1}}) s = '0;
      else                            s = code + 1'b1;
      return s;
   endfunction

endpackage

// File: rtl/lct_regs.sv
module lct_regs
   import lct_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int VEC_W       = 8,
   parameter bit DEADLINE_OK = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            wr_sel,
   input  logic [31:0]           wr_data,
   output logic [CNT_W-1:0]      init_q,
   output tmode_e                mode_q,
   output logic                  masked_q,
   output logic [VEC_W-1:0]      vector_q,
   output logic [DIV_CODE_W-1:0] div_code_q,
   output logic                  load_pulse,
   output logic [CNT_W-1:0]      load_value
);

   logic   wr_entry, wr_init, wr_div;
   tmode_e mode_next;

   assign wr_entry = wr_en && (wsel_e'(wr_sel) == SEL_ENTRY);
   assign wr_init  = wr_en && (wsel_e'(wr_sel) == SEL_INIT);
   assign wr_div   = wr_en && (wsel_e'(wr_sel) == SEL_DIV);

   generate
      if (DEADLINE_OK) begin : g_mode_full
         assign mode_next = tmode_e'(wr_data[ENTRY_MODE_HI:ENTRY_MODE_LO]);
      end else begin : g_mode_legacy
         // deadline bit is stripped when the mode is not supported
         assign mode_next = tmode_e'({1'b0, wr_data[ENTRY_MODE_LO]});
      end
   endgenerate

   // initial-count writes are dropped while deadline mode is selected
   assign load_pulse = wr_init && (mode_q != MODE_DEADLINE);
   assign load_value = wr_data[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q     <= '0;
         mode_q     <= MODE_ONESHOT;
         masked_q   <= 1'b1;
         vector_q   <= '0;
         div_code_q <= '0;
      end else begin
         if (load_pulse) init_q <= load_value;
         if (wr_entry) begin
            mode_q   <= mode_next;
            masked_q <= wr_data[ENTRY_MASK_BIT];
            vector_q <= wr_data[VEC_W-1:0];
         end
         if (wr_div) div_code_q <= {wr_data[3], wr_data[1], wr_data[0]};
      end
   end

   generate
      if (!DEADLINE_OK) begin : g_chk_legacy
         AST_NO_DEADLINE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_entry |=> (mode_q != MODE_DEADLINE)); // R10
      end
   endgenerate

   AST_INIT_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_init |=> $stable(init_q)); // R9

endmodule

// File: rtl/lct_prescaler.sv
module lct_prescaler
   import lct_pkg::*;
#(
   parameter int PRE_W = MAX_SHIFT
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  restart,
   input  logic [DIV_CODE_W-1:0] div_code,
   output logic                  tick
);

   logic [PRE_W-1:0]      pre_q;
   logic [PRE_W-1:0]      limit;
   logic [DIV_CODE_W-1:0] shift;

   assign shift = code_to_shift(div_code);
   assign limit = ~({PRE_W{1'b1}} << shift);
   assign tick  = run && ((pre_q & limit) == limit);

   always_ff @(posedge clk) begin
      if (!rst_n)               pre_q <= '0;
      else if (restart || !run) pre_q <= '0;
      else if (tick)            pre_q <= '0;
      else                      pre_q <= pre_q + 1'b1;
   end

   AST_TICK_CLEARS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart) |=> (pre_q == '0)); // R11

endmodule

// File: rtl/lct_counter.sv
module lct_counter
   import lct_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_value,
   input  logic             tick,
   input  tmode_e           mode,
   input  logic             masked,
   input  logic [VEC_W-1:0] vector,
   input  logic [CNT_W-1:0] init_value,
   output logic [CNT_W-1:0] cur_q,
   output logic             running_q,
   output logic             irq_q,
   output logic [VEC_W-1:0] irq_vec_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic expiry;
   assign expiry = !load && running_q && tick && (cur_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q     <= '0;
         running_q <= 1'b0;
      end else if (load) begin
         cur_q     <= load_value;
         running_q <= |load_value;
      end else if (expiry) begin
         if (mode == MODE_PERIODIC) begin
            cur_q     <= init_value;
            running_q <= |init_value;
         end else begin
            cur_q     <= '0;
            running_q <= 1'b0;
         end
      end else if (running_q && tick) begin
         cur_q <= cur_q - ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q     <= 1'b0;
         irq_vec_q <= '0;
      end else begin
         irq_q <= expiry && !masked;
         if (expiry) irq_vec_q <= vector;
      end
   end

   AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cur_q == $past(load_value))); // R2
   AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (expiry && mode != MODE_PERIODIC) |=> (cur_q == '0 && !running_q)); // R7
   AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (expiry && mode == MODE_PERIODIC) |=> (cur_q == $past(init_value))); // R6
   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && running_q && tick && cur_q > ONE) |=> (cur_q == $past(cur_q) - ONE)); // R11
   AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_value == '0) |=> (!running_q && !irq_q)); // R8

endmodule

// File: rtl/local_countdown_timer.sv
module local_countdown_timer
   import lct_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int VEC_W       = 8,
   parameter bit DEADLINE_OK = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_sel,
   input  logic [31:0] wr_data,
   output logic [31:0] cur_count,
   output logic [31:0] init_count,
   output logic [31:0] entry_word,
   output logic        irq_req,
   output logic [7:0]  irq_vec
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 2..32");
      end
      if (VEC_W < 1 || VEC_W > 8) begin : g_bad_vec
         $error("VEC_W must lie in 1..8");
      end
   endgenerate

   logic [CNT_W-1:0]      init_q, load_value, cur_q;
   tmode_e                mode_q;
   logic                  masked_q, load_pulse, tick, running_q, irq_q;
   logic [VEC_W-1:0]      vector_q, irq_vec_q;
   logic [DIV_CODE_W-1:0] div_code_q;

   lct_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W), .DEADLINE_OK(DEADLINE_OK)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .init_q     (init_q),
      .mode_q     (mode_q),
      .masked_q   (masked_q),
      .vector_q   (vector_q),
      .div_code_q (div_code_q),
      .load_pulse (load_pulse),
      .load_value (load_value)
   );

   lct_prescaler #(.PRE_W(MAX_SHIFT)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (running_q),
      .restart  (load_pulse),
      .div_code (div_code_q),
      .tick     (tick)
   );

   lct_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_pulse),
      .load_value (load_value),
      .tick       (tick),
      .mode       (mode_q),
      .masked     (masked_q),
      .vector     (vector_q),
      .init_value (init_q),
      .cur_q      (cur_q),
      .running_q  (running_q),
      .irq_q      (irq_q),
      .irq_vec_q  (irq_vec_q)
   );

   always_comb begin
      entry_word = '0;
      entry_word[VEC_W-1:0]                   = vector_q;
      entry_word[ENTRY_MASK_BIT]              = masked_q;
      entry_word[ENTRY_MODE_HI:ENTRY_MODE_LO] = mode_q;
   end

   assign cur_count  = 32'(cur_q);
   assign init_count = 32'(init_q);
   assign irq_req    = irq_q;
   assign irq_vec    = 8'(irq_vec_q);

   AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> $past(tick)); // R5
   AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> !$past(entry_word[ENTRY_MASK_BIT])); // R5
   AST_DEADLINE_IGNORES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && entry_word[ENTRY_MODE_HI:ENTRY_MODE_LO] == 2'b10)
      |=> $stable(init_count)); // R9

endmodule

// File: tb/local_countdown_timer_bench.sv
module local_countdown_timer_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = 32'd0;
   logic [31:0] cur_count, init_count, entry_word;
   logic        irq_req;
   logic [7:0]  irq_vec;
   logic [31:0] dl_cur, dl_init, dl_entry;
   logic        dl_irq;
   logic [7:0]  dl_vec;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   int          exp_cyc[$];
   logic [7:0]  exp_vec[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   local_countdown_timer u_local_countdown_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .cur_count(cur_count), .init_count(init_count), .entry_word(entry_word),
      .irq_req(irq_req), .irq_vec(irq_vec)
   );

   local_countdown_timer #(.DEADLINE_OK(1'b1)) u_local_countdown_timer_dl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .cur_count(dl_cur), .init_count(dl_init), .entry_word(dl_entry),
      .irq_req(dl_irq), .irq_vec(dl_vec)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   // drives one write; returns the bench cycle index of the loading edge
   task automatic reg_write(input logic [1:0] sel, input logic [31:0] d, output int at);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      at = cyc;
   endtask

   task automatic expect_irq(input int at, input logic [7:0] v);
      exp_cyc.push_back(at);
      exp_vec.push_back(v);
   endtask

   // monitor: scoreboard of interrupt requests
   always @(negedge clk) begin
      if (rst_n && !done) begin
         while (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
            total++; bad++;
            $display("FAIL R3: missing irq actual=none expected=cycle %0d", exp_cyc[0]);
            void'(exp_cyc.pop_front());
            void'(exp_vec.pop_front());
         end
         if (irq_req) begin
            total++;
            if (exp_cyc.size() == 0) begin
               bad++;
               $display("FAIL R5: unexpected irq actual=cycle %0d vec 0x%0h expected=none", cyc, irq_vec);
            end else begin
               if (exp_cyc[0] != cyc || exp_vec[0] !== irq_vec) begin
                  bad++;
                  $display("FAIL R3/R5: irq actual=cycle %0d vec 0x%0h expected=cycle %0d vec 0x%0h",
                           cyc, irq_vec, exp_cyc[0], exp_vec[0]);
               end
               void'(exp_cyc.pop_front());
               void'(exp_vec.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int t0;
      int t1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 cur", cur_count, 32'd0);
      check("R1 init", init_count, 32'd0);
      check("R1 entry", entry_word, 32'h0001_0000);
      check("R1 irq", {31'd0, irq_req}, 32'd0);

      // R4 code 111 -> divide by 1; R3 one-shot period
      reg_write(2'd2, 32'h0000_000B, t0);
      reg_write(2'd0, 32'h0000_0031, t0);
      reg_write(2'd1, 32'd5, t0);
      expect_irq(t0 + 5, 8'h31);
      check("R2 load", cur_count, 32'd5);
      repeat (10) @(negedge clk);
      check("R7 oneshot zero", cur_count, 32'd0);
      repeat (10) @(negedge clk);
      check("R7 stays zero", cur_count, 32'd0);

      // R4 code 000 -> divide by 2
      reg_write(2'd2, 32'h0000_0000, t0);
      reg_write(2'd1, 32'd3, t0);
      expect_irq(t0 + 6, 8'h31);
      repeat (10) @(negedge clk);

      // R4 code 001 -> divide by 4; R11 tick rate
      reg_write(2'd2, 32'h0000_0001, t0);
      reg_write(2'd1, 32'd10, t0);
      expect_irq(t0 + 40, 8'h31);
      repeat (8) @(negedge clk);
      check("R11 after 8 cycles", cur_count, 32'd8);
      repeat (40) @(negedge clk);

      // R4 code 100 (bit3) -> divide by 32
      reg_write(2'd2, 32'h0000_0008, t0);
      reg_write(2'd1, 32'd2, t0);
      expect_irq(t0 + 64, 8'h31);
      repeat (70) @(negedge clk);

      // R4 code 110 -> divide by 128
      reg_write(2'd2, 32'h0000_000A, t0);
      reg_write(2'd1, 32'd1, t0);
      expect_irq(t0 + 128, 8'h31);
      repeat (135) @(negedge clk);

      // R6 periodic reload, then R8 stop by zero
      reg_write(2'd2, 32'h0000_000B, t0);
      reg_write(2'd0, 32'h0002_0044, t0);
      check("R6 entry periodic", entry_word, 32'h0002_0044);
      reg_write(2'd1, 32'd7, t0);
      expect_irq(t0 + 7, 8'h44);
      expect_irq(t0 + 14, 8'h44);
      expect_irq(t0 + 21, 8'h44);
      while (cyc < t0 + 23) @(negedge clk);
      reg_write(2'd1, 32'd0, t1);
      check("R8 stopped", cur_count, 32'd0);
      repeat (30) @(negedge clk);
      check("R8 still zero", cur_count, 32'd0);

      // R5 masked expiry produces no request
      reg_write(2'd0, 32'h0001_0055, t0);
      reg_write(2'd1, 32'd4, t0);
      repeat (10) @(negedge clk);
      check("R5 masked expired", cur_count, 32'd0);

      // R2 reload while running restarts from the new value
      reg_write(2'd0, 32'h0000_0088, t0);
      reg_write(2'd1, 32'd100, t0);
      repeat (10) @(negedge clk);
      reg_write(2'd1, 32'd6, t1);
      check("R2 reload", cur_count, 32'd6);
      expect_irq(t1 + 6, 8'h88);
      repeat (12) @(negedge clk);

      // R8 zero mid-count
      reg_write(2'd0, 32'h0000_0066, t0);
      reg_write(2'd1, 32'd50, t0);
      repeat (10) @(negedge clk);
      reg_write(2'd1, 32'd0, t1);
      check("R8 mid stop", cur_count, 32'd0);
      repeat (60) @(negedge clk);

      // R10 / R9 deadline selection (masked, vector 0x77, mode 10)
      reg_write(2'd0, 32'h0005_0077, t0);
      check("R10 bit cleared", entry_word, 32'h0001_0077);
      check("R9 dl entry kept", dl_entry, 32'h0005_0077);
      reg_write(2'd1, 32'd9, t0);
      check("R9 dl init ignored", dl_init, 32'd0);
      check("R9 dl cur ignored", dl_cur, 32'd0);
      check("R10 legacy loads", cur_count, 32'd9);
      repeat (15) @(negedge clk);
      check("R9 dl cur still", dl_cur, 32'd0);

      check("R3 all irqs seen", exp_cyc.size(), 32'd0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule